// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block follows the rounding stage of a scalar or packed floating-point datapath. In every valid result cycle, each lane presents four things: its operation class, the class of each operand, the rounded-result indicators (overflow, tiny, inexact, sign) and the rounded result word. From these the block derives three exception conditions per lane: division by zero, numeric overflow and numeric underflow. It merges them into sticky flag bits of a 32-bit control/status register. When flush-to-zero applies, it replaces a tiny result by a signed zero. In the same cycle it raises a trap request if any condition that occurred is not masked.

Software reaches the register through a single-cycle write port and a continuously visible read value. Flags leave the register only through a write. The mask bits and the flush-to-zero control live in the same register. After reset every mask bit is set and every flag is clear.

Top module: `fpx_status_unit`

## Requirements
- R1: Divide-by-zero is raised for a lane only when its operation class is divide (3), its first operand class is finite non-zero (1) and its second operand class is zero (0). Operation classes are 0 add, 1 subtract, 2 multiply, 3 divide, 4 horizontal/alternating add-subtract, 5 double-to-single convert, and 6 and 7 non-arithmetic. Operand classes are 0 zero, 1 finite non-zero, 2 infinite and 3 NaN.
- R2: Overflow is raised when the lane's overflow indicator is 1 and its operation class is 0 to 5. It is never raised for classes 6 or 7.
- R3: With the underflow mask (register bit 11) at 0, underflow is raised for an arithmetic class whenever the tiny indicator is 1.
- R4: With the underflow mask at 1, underflow is raised only when both tiny and inexact are 1.
- R5: The conditions of all lanes are ORed into sticky flags: bit 2 for divide-by-zero, bit 3 for overflow and bit 4 for underflow. This happens only in cycles with valid at 1. Without a write, a flag never returns to 0.
- R6: A register write replaces all 32 bits with the write data. If conditions arise in the same cycle, they are ORed on top of the written value.
- R7: When valid, tiny, the flush-to-zero bit (bit 15) and the underflow mask are all 1 for a lane, its result is replaced by a zero carrying the lane's sign. For double format (format select 1) the sign goes in bit 63 and all other bits are 0. For single format it goes in bit 31 and all other bits are 0. In every other case the result passes through unchanged.
- R8: The trap request is 1 in the same cycle as a valid result when any raised condition has its mask bit at 0 (divide-by-zero mask bit 9, overflow mask bit 10, underflow mask bit 11). Otherwise it is 0.
- R9: After reset the register reads 0x00001F80, meaning mask bits 7 to 12 are set and all flags are clear.
- R10: The flush-to-zero bit and the denormals-are-zero bit (bit 6) have no effect on divide-by-zero or overflow detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A result is present on all lanes |
| op_i | input | 3*LANES | Operation class per lane |
| cls_a_i | input | 2*LANES | First operand class per lane |
| cls_b_i | input | 2*LANES | Second operand class per lane |
| ovf_i | input | LANES | Rounded result exceeds largest finite |
| tiny_i | input | LANES | Rounded result below smallest normal |
| inexact_i | input | LANES | Rounded result is inexact |
| sign_i | input | LANES | Sign of the true result |
| dbl_i | input | LANES | Format select, 1 double, 0 single |
| res_i | input | RES_W*LANES | Rounded result per lane |
| res_o | output | RES_W*LANES | Result after flush substitution |
| trap_o | output | 1 | Unmasked condition in this cycle |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register contents |

## Verification
The assertions assume that valid_i, the operation and class codes and the write strobe are known after reset. They also assume that a lane's indicators mean something only while valid_i is high, and that the upstream rounder keeps its overflow and tiny indicators exclusive. The stimulus draws random codes across the full encoding space but clears tiny whenever it sets overflow. It mixes in register writes with random masks, flags and flush control, and it adds directed cases for each detection rule and for same-cycle write-and-raise.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int CSR_W = 32;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_DIV = 3'd3,
    OP_HAS = 3'd4, OP_CVT = 3'd5, OP_NA6 = 3'd6, OP_NA7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CL_ZERO = 2'd0, CL_FIN = 2'd1, CL_INF = 2'd2, CL_NAN = 2'd3
  } cls_e;

  // register bit placement
  localparam int B_DAZ = 6;
  localparam int B_DZF = 2;
  localparam int B_OVF = 3;
  localparam int B_UNF = 4;
  localparam int B_DZM = 9;
  localparam int B_OVM = 10;
  localparam int B_UNM = 11;
  localparam int B_FTZ = 15;
  localparam logic [CSR_W-1:0] CSR_RST = 32'h0000_1F80;

  function automatic logic op_arith(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic dz_rule(input logic [2:0] op, input logic [1:0] a,
                                   input logic [1:0] b);
    return (op == OP_DIV) && (a == CL_FIN) && (b == CL_ZERO);
  endfunction

  function automatic logic uf_rule(input logic [2:0] op, input logic tiny,
                                   input logic inexact, input logic masked);
    return op_arith(op) && tiny && (!masked || inexact);
  endfunction
endpackage

// File: rtl/fpx_lane_detect.sv
module fpx_lane_detect
  import fpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [2:0] op_i,
  input  logic [1:0] cls_a_i,
  input  logic [1:0] cls_b_i,
  input  logic       ovf_i,
  input  logic       tiny_i,
  input  logic       inexact_i,
  input  logic       uf_masked_i,
  output logic       dz_o,
  output logic       of_o,
  output logic       uf_o
);
  always_comb begin
    dz_o = valid_i && dz_rule(op_i, cls_a_i, cls_b_i);
    of_o = valid_i && ovf_i && op_arith(op_i);
    uf_o = valid_i && uf_rule(op_i, tiny_i, inexact_i, uf_masked_i);
  end

  a_r1_dz_needs_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    dz_o |-> (cls_b_i == 2'd0 && op_i == 3'd3));
  a_r2_no_overflow_nonarith: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[2:1] == 2'b11) |-> !of_o);
  a_r4_masked_uf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_o && uf_masked_i) |-> inexact_i);
endmodule

// File: rtl/fpx_ftz.sv
module fpx_ftz #(
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             dbl_i,
  input  logic             sign_i,
  input  logic [RES_W-1:0] res_i,
  output logic [RES_W-1:0] res_o
);
  localparam int SGL_W = RES_W / 2;

  function automatic logic [RES_W-1:0] signed_zero(input logic dbl, input logic s);
    logic [RES_W-1:0] z;
    z = '0;
    if (dbl) z[RES_W-1] = s;
    else     z[SGL_W-1] = s;
    return z;
  endfunction

  assign res_o = flush_i ? signed_zero(dbl_i, sign_i) : res_i;

  a_r7_flush_single_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !dbl_i) |-> (res_o[RES_W-1:SGL_W] == '0));
  a_r7_flush_at_most_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> $onehot0(res_o));
endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             set_dz_i,
  input  logic             set_of_i,
  input  logic             set_uf_i,
  output logic [CSR_W-1:0] q_o
);
  logic [CSR_W-1:0] base, raise;

  always_comb begin
    base = we_i ? wdata_i : q_o;
    raise = '0;
    raise[B_DZF] = set_dz_i;
    raise[B_OVF] = set_of_i;
    raise[B_UNF] = set_uf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= CSR_RST;
    else        q_o <= base | raise;
  end

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ((q_o[4:2] & $past(q_o[4:2])) == $past(q_o[4:2])));
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !set_dz_i && !set_of_i && !set_uf_i) |=> q_o == $past(wdata_i));
  a_r5_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_of_i |=> q_o[B_OVF]);
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int LANES = 2,
  parameter int RES_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic [3*LANES-1:0]     op_i,
  input  logic [2*LANES-1:0]     cls_a_i,
  input  logic [2*LANES-1:0]     cls_b_i,
  input  logic [LANES-1:0]       ovf_i,
  input  logic [LANES-1:0]       tiny_i,
  input  logic [LANES-1:0]       inexact_i,
  input  logic [LANES-1:0]       sign_i,
  input  logic [LANES-1:0]       dbl_i,
  input  logic [RES_W*LANES-1:0] res_i,
  output logic [RES_W*LANES-1:0] res_o,
  output logic                   trap_o,
  input  logic                   csr_we_i,
  input  logic [31:0]            csr_wdata_i,
  output logic [31:0]            csr_rdata_o
);
  logic [CSR_W-1:0] csr_q;
  logic [LANES-1:0] dz_l, of_l, uf_l, flush_l;
  logic             any_dz, any_of, any_uf;
  logic             um, ftz;

  assign um  = csr_q[B_UNM];
  assign ftz = csr_q[B_FTZ];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpx_lane_detect u_det (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
      .op_i(op_i[3*g +: 3]), .cls_a_i(cls_a_i[2*g +: 2]), .cls_b_i(cls_b_i[2*g +: 2]),
      .ovf_i(ovf_i[g]), .tiny_i(tiny_i[g]), .inexact_i(inexact_i[g]),
      .uf_masked_i(um), .dz_o(dz_l[g]), .of_o(of_l[g]), .uf_o(uf_l[g])
    );
    assign flush_l[g] = valid_i && tiny_i[g] && um && ftz;
    fpx_ftz #(.RES_W(RES_W)) u_ftz (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_l[g]), .dbl_i(dbl_i[g]),
      .sign_i(sign_i[g]), .res_i(res_i[RES_W*g +: RES_W]),
      .res_o(res_o[RES_W*g +: RES_W])
    );
  end

  assign any_dz = |dz_l;
  assign any_of = |of_l;
  assign any_uf = |uf_l;

  assign trap_o = (any_dz && !csr_q[B_DZM]) || (any_of && !csr_q[B_OVM]) ||
                  (any_uf && !um);

  fpx_csr u_csr (
    .clk(clk), .rst_n(rst_n), .we_i(csr_we_i), .wdata_i(csr_wdata_i),
    .set_dz_i(any_dz), .set_of_i(any_of), .set_uf_i(any_uf), .q_o(csr_q)
  );

  assign csr_rdata_o = csr_q;

  a_r8_trap_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> valid_i);
  a_r8_trap_needs_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !(csr_q[B_DZM] && csr_q[B_OVM] && csr_q[B_UNM]));
  a_r5_flag_follows_condition: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && any_uf) |=> csr_rdata_o[B_UNF]);
endmodule

// File: tb/fpx_status_unit_tb.sv
module fpx_status_unit_tb;
  localparam int L = 2;
  localparam int W = 64;

  logic clk = 0, rst_n = 0;
  logic valid_i = 0;
  logic [3*L-1:0] op_i = '0;
  logic [2*L-1:0] cls_a_i = '0, cls_b_i = '0;
  logic [L-1:0] ovf_i = '0, tiny_i = '0, inexact_i = '0, sign_i = '0, dbl_i = '0;
  logic [W*L-1:0] res_i = '0, res_o;
  logic trap_o, csr_we_i = 0;
  logic [31:0] csr_wdata_i = '0, csr_rdata_o;

  int vectors = 0, errors = 0;
  logic [31:0] model;
  bit done = 0;

  always #10 clk = ~clk;

  fpx_status_unit #(.LANES(L), .RES_W(W)) u_dut (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench restatement of the rules
  function automatic logic [2:0] lane_cond(input int k, input logic [31:0] c);
    logic [2:0] op; logic [1:0] a, b; logic ar; logic [2:0] r;
    op = op_i[3*k +: 3]; a = cls_a_i[2*k +: 2]; b = cls_b_i[2*k +: 2];
    ar = (op != 3'd6) && (op != 3'd7);
    r = 3'b000;
    if (valid_i) begin
      r[0] = (op == 3'd3) & (a == 2'd1) & (b == 2'd0);
      r[1] = ar & ovf_i[k];
      r[2] = ar & tiny_i[k] & (c[11] ? inexact_i[k] : 1'b1);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] lane_res(input int k, input logic [31:0] c);
    logic [W-1:0] z;
    if (valid_i && tiny_i[k] && c[11] && c[15]) begin
      z = '0;
      if (dbl_i[k]) z[63] = sign_i[k]; else z[31] = sign_i[k];
      return z;
    end
    return res_i[W*k +: W];
  endfunction

  // drive at negedge, check comb outputs, advance one clock, check register
  task automatic step(input string req);
    logic [2:0] any; logic texp; logic [W*L-1:0] rexp;
    #1;
    any = 3'b000;
    for (int k = 0; k < L; k++) begin
      any |= lane_cond(k, model);
      rexp[W*k +: W] = lane_res(k, model);
    end
    texp = (any[0] & ~model[9]) | (any[1] & ~model[10]) | (any[2] & ~model[11]);
    check({req, "/R8 trap"}, {127'b0, trap_o}, {127'b0, texp});
    check({req, "/R7 result"}, res_o, rexp);
    if (csr_we_i) model = csr_wdata_i;
    model[2] |= any[0]; model[3] |= any[1]; model[4] |= any[2];
    @(negedge clk);
    check({req, "/R5 R6 register"}, {96'b0, csr_rdata_o}, {96'b0, model});
    valid_i = 0; csr_we_i = 0; ovf_i = '0; tiny_i = '0; inexact_i = '0;
  endtask

  task automatic wr(input logic [31:0] d);
    csr_we_i = 1; csr_wdata_i = d; step("R6 write");
  endtask

  task automatic lane0(input logic [2:0] op, input logic [1:0] a, input logic [1:0] b,
                       input logic ov, input logic tn, input logic ix);
    valid_i = 1; op_i = {3'd6, op}; cls_a_i = {2'd0, a}; cls_b_i = {2'd1, b};
    ovf_i = {1'b0, ov}; tiny_i = {1'b0, tn}; inexact_i = {1'b0, ix};
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    model = 32'h1F80;
    check("R9 reset register", {96'b0, csr_rdata_o}, 128'h1F80);
    check("R9 reset trap", {127'b0, trap_o}, 128'b0);
    rst_n = 1;
    @(negedge clk);
    // R1 directed: finite/zero divide, masked -> flag only
    lane0(3'd3, 2'd1, 2'd0, 0, 0, 0); step("R1 dz masked");
    lane0(3'd3, 2'd2, 2'd0, 0, 0, 0); step("R1 inf/zero no dz");
    lane0(3'd2, 2'd1, 2'd0, 0, 0, 0); step("R1 mul no dz");
    wr(32'h0000_0000);             // R6 clear all: unmask everything
    lane0(3'd3, 2'd1, 2'd0, 0, 0, 0); step("R1 dz unmasked trap");
    wr(32'h0000_8040);             // R10 FTZ+DAZ, all unmasked
    lane0(3'd5, 2'd1, 2'd1, 1, 0, 1); step("R10 R2 ovf with ftz");
    lane0(3'd6, 2'd1, 2'd1, 1, 0, 1); step("R2 non-arith no ovf");
    lane0(3'd0, 2'd1, 2'd1, 0, 1, 0); step("R3 unmasked tiny exact");
    wr(32'h0000_8800);             // UM + FTZ
    lane0(3'd1, 2'd1, 2'd1, 0, 1, 0); step("R4 masked tiny exact");
    lane0(3'd1, 2'd1, 2'd1, 0, 1, 1); step("R4 masked tiny inexact");
    sign_i = 2'b11; dbl_i = 2'b01; res_i = {64'h1234, 64'h5678};
    valid_i = 1; tiny_i = 2'b11; op_i = {3'd2, 3'd2}; step("R7 flush both formats");
    csr_we_i = 1; csr_wdata_i = 32'h0; lane0(3'd3, 2'd1, 2'd0, 0, 0, 0);
    step("R6 write with raise");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        csr_we_i = 1; csr_wdata_i = $urandom;
      end
      valid_i = $urandom_range(0, 3) != 0;
      op_i = $urandom; cls_a_i = $urandom; cls_b_i = $urandom;
      ovf_i = $urandom; tiny_i = $urandom & ~ovf_i; inexact_i = $urandom;
      sign_i = $urandom; dbl_i = $urandom;
      res_i = {$urandom, $urandom, $urandom, $urandom};
      step("R1 R2 R3 R4 R10 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule